// File: doc/BRIEF.md
# Way-Predicted Instruction Cache Data Read Controller

This block decides which data-array banks of a multi-way instruction cache are switched on for each fetch. With prediction active, it keeps for every set the way that last supplied data there and turns on only that way's bank. The tag compare runs at the same time as this read. If the tag result names a different way, the block issues one corrective read of the right bank, raises `stall` for that cycle and delivers the word one cycle late. If no way hits, no corrective read is made and a miss flag is raised.

When `pred_off` is high, every bank is read for each fetch and the tag hit vector picks the word, so there is never a corrective read. This costs more array activity. Software is expected to change `pred_off` only while the cache holds no valid lines. A saturating counter records corrective reads so that tests can read it.

The control is a three-state machine. `ST_IDLE` means no read is in flight. `ST_READ` means the first read was issued in the previous cycle. `ST_RETRY` means the corrective read was issued in the previous cycle. The transitions are: `ST_IDLE`→`ST_READ` on an accepted request. `ST_READ`→`ST_RETRY` on a misprediction. `ST_READ`→`ST_READ` and `ST_RETRY`→`ST_READ` on a new accepted request. `ST_READ`→`ST_IDLE` and `ST_RETRY`→`ST_IDLE` when no request is accepted.

Top module: `wp_fetch_ctrl`

## Requirements
- R1: While reset is held and no request is driven, `bank_en`, `rdata_valid`, `stall`, `miss` and `mispred_cnt` are all zero, and every set's prediction is way 0.
- R2: With `pred_off` low, an accepted request turns on, in the same cycle, exactly one bank: bit k of `bank_en` for predicted way k. `bank_set` equals `req_set` in that cycle.
- R3: When the hit way equals the predicted way, `rdata_valid` is high in the next cycle. `rdata` is then that way's bank word, taken from bits [k*DATA_W +: DATA_W] of `bank_rdata`, and `stall` stays low.
- R4: When the hit way differs from the prediction, the next cycle has `stall` high and `rdata_valid` low. In that cycle `bank_en` has only the hit way's bit set and `bank_set` repeats the request's set. The word from the hit way arrives with `rdata_valid` in the cycle after that.
- R5: With `pred_off` high, an accepted request turns on all banks. In the next cycle the word comes from the way whose bit is set in `hit_vec`, and `stall` never rises.
- R6: When `hit_vec` is all zero (bit w set means way w hit, and at most one bit is set), the next cycle has `miss` high. In that cycle `rdata_valid` and `stall` are low, no corrective read is issued, and the set's prediction is left unchanged.
- R7: The prediction for a set is the way that hit there most recently, and each set keeps its own prediction.
- R8: A refill write (`refill_valid`, `refill_set`, `refill_way`) sets that set's prediction. If a hit updates the same set in the same cycle, the refill value is kept.
- R9: A request presented while `stall` is high is ignored. It turns on no bank for itself, produces no output and changes no prediction.
- R10: `mispred_cnt` rises by one for each misprediction and holds at all ones. It never counts in `pred_off` mode.
- R11: Requests are accepted on consecutive cycles whenever `stall` is low, and each produces its own result in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_off | input | 1 | High: read all banks, no prediction |
| req_valid | input | 1 | Fetch request |
| req_set | input | IDX_W | Set index of the fetch |
| hit_vec | input | NUM_WAYS | Tag-compare result, one bit per way |
| refill_valid | input | 1 | Refill completed into a way |
| refill_set | input | IDX_W | Set of the refill |
| refill_way | input | WAY_W | Way of the refill |
| bank_en | output | NUM_WAYS | Per-way data bank enable |
| bank_set | output | IDX_W | Set address sent to the banks |
| bank_rdata | input | NUM_WAYS*DATA_W | Bank read words, valid one cycle after enable |
| rdata_valid | output | 1 | Fetched word valid |
| rdata | output | DATA_W | Fetched word |
| stall | output | 1 | Corrective read in progress |
| miss | output | 1 | No way hit for the previous request |
| mispred_cnt | output | CNT_W | Saturating misprediction count |

## Verification
The bench uses several request patterns. Repeated fetches to one set first hit the predicted way and then a different way, which separates a correct prediction from a corrective read. The same hit ways are then sent to different sets, which shows whether history is kept per set. All-zero hit vectors show that a miss issues no second read. Requests held during a stall, and refills that collide with hits, expose priority mistakes. A long random stream of back-to-back requests is run with prediction on and again with it off, and each bank returns a word that encodes its way and set, so a wrong bank enable or a wrong mux select shows up as a wrong word.

// File: rtl/wp_fetch_pkg.sv
`timescale 1ns/1ps
package wp_fetch_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_RETRY = 2'd2
    } rd_state_e;
endpackage

// File: rtl/wp_hit_encode.sv
`timescale 1ns/1ps
module wp_hit_encode #(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0] hit_vec,
    output logic                hit_any,
    output logic [WAY_W-1:0]    hit_way
);
    always_comb begin
        hit_any = |hit_vec;
        hit_way = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (hit_vec[w]) hit_way = hit_way | WAY_W'(w);
        end
    end
endmodule

// File: rtl/wp_pred_table.sv
`timescale 1ns/1ps
module wp_pred_table #(
    parameter int SETS  = 64,
    parameter int WAY_W = 2,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_set,
    output logic [WAY_W-1:0] rd_way,
    input  logic             hit_we,
    input  logic [IDX_W-1:0] hit_set,
    input  logic [WAY_W-1:0] hit_way,
    input  logic             fill_we,
    input  logic [IDX_W-1:0] fill_set,
    input  logic [WAY_W-1:0] fill_way
);
    logic [WAY_W-1:0] last_way_q [SETS];

    // Refill is written last so it wins over a same-set hit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) last_way_q[s] <= '0;
        end else begin
            if (hit_we)  last_way_q[hit_set]  <= hit_way;
            if (fill_we) last_way_q[fill_set] <= fill_way;
        end
    end

    assign rd_way = last_way_q[rd_set];
endmodule

// File: rtl/wp_sat_counter.sv
`timescale 1ns/1ps
module wp_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    count <= '0;
        else if (bump && count != '1)  count <= count + CNT_W'(1);
    end
endmodule

// File: rtl/wp_fetch_ctrl.sv
`timescale 1ns/1ps
module wp_fetch_ctrl
    import wp_fetch_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int SETS     = 64,
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 16,
    localparam int WAY_W   = $clog2(NUM_WAYS),
    localparam int IDX_W   = $clog2(SETS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pred_off,
    input  logic                       req_valid,
    input  logic [IDX_W-1:0]           req_set,
    input  logic [NUM_WAYS-1:0]        hit_vec,
    input  logic                       refill_valid,
    input  logic [IDX_W-1:0]           refill_set,
    input  logic [WAY_W-1:0]           refill_way,
    output logic [NUM_WAYS-1:0]        bank_en,
    output logic [IDX_W-1:0]           bank_set,
    input  logic [NUM_WAYS*DATA_W-1:0] bank_rdata,
    output logic                       rdata_valid,
    output logic [DATA_W-1:0]          rdata,
    output logic                       stall,
    output logic                       miss,
    output logic [CNT_W-1:0]           mispred_cnt
);
    localparam logic [NUM_WAYS-1:0] ONE_BANK = NUM_WAYS'(1);

    rd_state_e        state_q, state_d;
    logic [WAY_W-1:0] rd_way_q;
    logic [IDX_W-1:0] rd_set_q;
    logic             rd_nohit_q;
    logic             rd_wrong_q;

    logic             accept;
    logic             hit_any;
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] guess_way;
    logic             wrong_now;
    logic [DATA_W-1:0] bank_word [NUM_WAYS];

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_unpack
        assign bank_word[w] = bank_rdata[w*DATA_W +: DATA_W];
    end

    wp_hit_encode #(.NUM_WAYS(NUM_WAYS)) i_enc (
        .hit_vec (hit_vec),
        .hit_any (hit_any),
        .hit_way (hit_way)
    );

    wp_pred_table #(.SETS(SETS), .WAY_W(WAY_W)) i_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_set   (req_set),
        .rd_way   (guess_way),
        .hit_we   (accept && hit_any),
        .hit_set  (req_set),
        .hit_way  (hit_way),
        .fill_we  (refill_valid),
        .fill_set (refill_set),
        .fill_way (refill_way)
    );

    assign stall     = (state_q == ST_READ) && rd_wrong_q;
    assign accept    = req_valid && !stall;
    assign wrong_now = accept && !pred_off && hit_any && (hit_way != guess_way);

    wp_sat_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (wrong_now),
        .count (mispred_cnt)
    );

    // State register and per-read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            rd_way_q   <= '0;
            rd_set_q   <= '0;
            rd_nohit_q <= 1'b0;
            rd_wrong_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                rd_way_q   <= hit_way;
                rd_set_q   <= req_set;
                rd_nohit_q <= !hit_any;
                rd_wrong_q <= wrong_now;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE:  state_d = accept ? ST_READ : ST_IDLE;
            ST_READ:  begin
                if (rd_wrong_q)  state_d = ST_RETRY;
                else if (accept) state_d = ST_READ;
                else             state_d = ST_IDLE;
            end
            ST_RETRY: state_d = accept ? ST_READ : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        bank_en     = '0;
        bank_set    = req_set;
        rdata_valid = 1'b0;
        miss        = 1'b0;
        unique case (state_q)
            ST_READ: begin
                if (rd_wrong_q) begin
                    bank_en  = ONE_BANK << rd_way_q;
                    bank_set = rd_set_q;
                end else if (rd_nohit_q) begin
                    miss = 1'b1;
                end else begin
                    rdata_valid = 1'b1;
                end
            end
            ST_RETRY: rdata_valid = 1'b1;
            default: ;
        endcase
        if (accept) bank_en = pred_off ? '1 : (ONE_BANK << guess_way);
    end

    assign rdata = bank_word[rd_way_q];
endmodule

// File: rtl/wp_fetch_ctrl_chk.sv
`timescale 1ns/1ps
module wp_fetch_ctrl_chk #(
    parameter int NUM_WAYS = 4,
    parameter int CNT_W    = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                pred_off,
    input logic [NUM_WAYS-1:0] bank_en,
    input logic                stall,
    input logic                rdata_valid,
    input logic                miss,
    input logic [CNT_W-1:0]    mispred_cnt
);
    // R4
    stall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);
    // R4
    stall_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> rdata_valid);
    // R6
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> (!rdata_valid && !stall));
    // R2
    single_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_off |-> $onehot0(bank_en));
    // R9
    stall_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> ($countones(bank_en) == 1));
    // R5
    off_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_off && $past(pred_off)) |-> !stall);
    // R10
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mispred_cnt != $past(mispred_cnt)) |-> (mispred_cnt == $past(mispred_cnt) + CNT_W'(1)));
endmodule

bind wp_fetch_ctrl wp_fetch_ctrl_chk #(.NUM_WAYS(NUM_WAYS), .CNT_W(CNT_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pred_off    (pred_off),
    .bank_en     (bank_en),
    .stall       (stall),
    .rdata_valid (rdata_valid),
    .miss        (miss),
    .mispred_cnt (mispred_cnt)
);

// File: tb/test_wp_fetch_ctrl.sv
`timescale 1ns/1ps
module test_wp_fetch_ctrl;
    localparam int NW   = 4;
    localparam int NS   = 64;
    localparam int DW   = 32;
    localparam int CW   = 4;
    localparam int WW   = 2;
    localparam int IW   = 6;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pred_off = 1'b0;
    logic          req_valid = 1'b0;
    logic [IW-1:0] req_set = '0;
    logic [NW-1:0] hit_vec = '0;
    logic          refill_valid = 1'b0;
    logic [IW-1:0] refill_set = '0;
    logic [WW-1:0] refill_way = '0;
    logic [NW-1:0] bank_en;
    logic [IW-1:0] bank_set;
    logic [NW*DW-1:0] bank_rdata;
    logic          rdata_valid;
    logic [DW-1:0] rdata;
    logic          stall;
    logic          miss;
    logic [CW-1:0] mispred_cnt;

    always #2 clk = ~clk;

    wp_fetch_ctrl #(.NUM_WAYS(NW), .SETS(NS), .DATA_W(DW), .CNT_W(CW)) i_wp_fetch_ctrl (
        .clk(clk), .rst_n(rst_n), .pred_off(pred_off), .req_valid(req_valid),
        .req_set(req_set), .hit_vec(hit_vec), .refill_valid(refill_valid),
        .refill_set(refill_set), .refill_way(refill_way), .bank_en(bank_en),
        .bank_set(bank_set), .bank_rdata(bank_rdata), .rdata_valid(rdata_valid),
        .rdata(rdata), .stall(stall), .miss(miss), .mispred_cnt(mispred_cnt)
    );

    function automatic logic [DW-1:0] patt(int w, int s);
        return 32'hA500_0000 | (w << 16) | s;
    endfunction

    // Behavioural banks: word appears the cycle after enable
    logic [DW-1:0] bank_q [NW];
    initial for (int w = 0; w < NW; w++) bank_q[w] = '0;
    always @(posedge clk)
        for (int w = 0; w < NW; w++)
            if (bank_en[w]) bank_q[w] <= patt(w, int'(bank_set));
    always_comb
        for (int w = 0; w < NW; w++) bank_rdata[w*DW +: DW] = bank_q[w];

    // Reference model
    localparam int K_NONE = 0, K_DATA = 1, K_MISS = 2, K_STALL = 3, K_RETRY = 4;
    int    m_kind, m_way, m_set, m_cnt;
    int    m_pred [NS];
    string m_tag;
    string phase = "R1 reset";
    int    n_checks = 0, n_err = 0, cyc = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_kind = K_NONE; m_cnt = 0; m_way = 0; m_set = 0; m_tag = "R1";
            for (int s = 0; s < NS; s++) m_pred[s] = 0;
        end else begin
            if (m_kind == K_STALL) begin
                m_kind = K_RETRY; m_tag = "R4";        // R9: request ignored
            end else if (req_valid) begin
                automatic bit hany = 0;
                automatic int hw = 0;
                for (int w = 0; w < NW; w++) if (hit_vec[w]) begin hany = 1; hw = w; end
                m_set = int'(req_set); m_way = hw;
                if (!hany) begin
                    m_kind = K_MISS; m_tag = "R6";
                end else if (pred_off || hw == m_pred[m_set]) begin
                    m_kind = K_DATA; m_tag = pred_off ? "R5" : "R3";
                end else begin
                    m_kind = K_STALL; m_tag = "R4";
                    if (m_cnt < CMAX) m_cnt++;
                end
                if (hany) m_pred[m_set] = hw;
            end else begin
                m_kind = K_NONE;
            end
            if (refill_valid) m_pred[int'(refill_set)] = int'(refill_way); // R8 refill wins
        end
    end

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s (%s): actual %0h expected %0h", req, what, phase, act, exp);
        end
    endtask

    always @(negedge clk) begin
        automatic logic [NW-1:0] e_en = '0;
        automatic int e_set = int'(req_set);
        automatic string en_tag;
        if (m_kind == K_STALL) begin
            e_en = NW'(1) << m_way; e_set = m_set; en_tag = "R4";
        end else if (req_valid) begin
            e_en = pred_off ? '1 : NW'(1) << m_pred[int'(req_set)];
            en_tag = pred_off ? "R5" : "R2";
        end else en_tag = rst_n ? "R2" : "R1";
        chk(en_tag, "bank_en", 64'(bank_en), 64'(e_en));
        if (e_en != 0) chk(en_tag, "bank_set", 64'(bank_set), 64'(e_set));
        chk(m_tag, "rdata_valid", 64'(rdata_valid), 64'(m_kind == K_DATA || m_kind == K_RETRY));
        if (m_kind == K_DATA || m_kind == K_RETRY)
            chk(m_tag, "rdata", 64'(rdata), 64'(patt(m_way, m_set)));
        chk(rst_n ? "R4" : "R1", "stall", 64'(stall), 64'(m_kind == K_STALL));
        chk(rst_n ? "R6" : "R1", "miss", 64'(miss), 64'(m_kind == K_MISS));
        chk(rst_n ? "R10" : "R1", "mispred_cnt", 64'(mispred_cnt), 64'(m_cnt));
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_err++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cyc);
            finish_run();
        end
    end

    task automatic step(bit v, int s, logic [NW-1:0] hv);
        req_valid = v; req_set = IW'(s); hit_vec = hv;
        @(posedge clk); #1;
        req_valid = 0; hit_vec = '0; refill_valid = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, '0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(1);

        phase = "R3/R4/R7 single set";
        step(1, 5, 4'b0001);              // correct (way 0)
        step(1, 5, 4'b0100);              // mispredict -> stall next
        step(0, 0, '0);                   // stall cycle
        step(1, 5, 4'b0100);              // R7: now correct
        step(1, 6, 4'b0100);              // R7: set 6 still predicts way 0
        step(0, 0, '0);
        idle(1);

        phase = "R6 miss";
        step(1, 7, 4'b0000);
        step(1, 7, 4'b0001);              // R6: prediction unchanged, correct
        idle(1);

        phase = "R9 request during stall";
        step(1, 20, 4'b0010);             // mispredict
        step(1, 21, 4'b1000);             // ignored during stall
        step(1, 21, 4'b1000);             // mispredict: set 21 untouched
        step(0, 0, '0);
        idle(1);

        phase = "R8 refill";
        refill_valid = 1; refill_set = 9; refill_way = 3;
        step(0, 0, '0);
        step(1, 9, 4'b1000);              // correct after refill
        refill_valid = 1; refill_set = 10; refill_way = 1;
        step(1, 10, 4'b0100);             // mispredict; refill wins for set 10
        step(0, 0, '0);
        step(1, 10, 4'b0010);             // correct if refill won
        idle(1);

        phase = "R10 saturation";
        for (int i = 0; i < 20; i++) begin
            step(1, 30, (i % 2) ? 4'b0010 : 4'b0100);
            step(0, 0, '0);
        end
        idle(1);

        phase = "R5 prediction off";
        pred_off = 1;
        step(1, 40, 4'b1000);
        step(1, 40, 4'b0001);
        step(1, 41, 4'b0000);
        step(1, 42, 4'b0010);
        idle(1);

        for (int pass = 0; pass < 2; pass++) begin
            phase = "R11 back-to-back stream";
            pred_off = (pass == 1);
            for (int i = 0; i < 400; i++) begin
                automatic int r = $urandom_range(0, 4);
                if ($urandom_range(0, 7) == 0) begin
                    refill_valid = 1;
                    refill_set = IW'($urandom_range(0, 3));
                    refill_way = WW'($urandom_range(0, 3));
                end
                step($urandom_range(0, 3) != 0, $urandom_range(0, 3),
                     (r == 4) ? 4'b0000 : NW'(1) << r);
            end
            idle(2);
        end
        finish_run();
    end
endmodule